// File: doc/BRIEF.md
# Bus Reset Pulse Sequencer

This block drives the active-low reset line of a shared peripheral bus. While the asynchronous power-good input is low the reset is held asserted. Once power-good rises, the release is deferred by a parameterised hold interval counted on a free-running timing clock, so that devices on the bus see a reset of guaranteed minimum length after supply ramp-up.

A one-cycle request strobe from control logic elsewhere starts a hard reset of the same minimum length. A second request that arrives while a pulse is running restarts the interval, which lengthens the pulse. Reset assertion on power loss uses an asynchronous path and does not wait for any clock. Only the release is synchronised, through a flop chain on the timing clock. A busy flag is high while the hold interval is being timed.

Top module: `bus_rst_seq`

## Requirements
- R1: While `pwr_good_i` is low, `bus_rst_n_o` is 0 and `busy_o` is 0. A falling `pwr_good_i` forces `bus_rst_n_o` to 0 at once, without waiting for a clock edge.
- R2: After `pwr_good_i` rises, `bus_rst_n_o` stays 0 through the next HOLD_CYCLES+1 rising clock edges and goes to 1 on the following edge. That delay is two synchroniser edges plus HOLD_CYCLES counting edges.
- R3: When the bus is out of reset, a request pulse (`sw_rst_req_i` = 1 at one rising edge) drives `bus_rst_n_o` to 0 from that edge for exactly HOLD_CYCLES clock cycles.
- R4: A request sampled k edges after an earlier request, with 1 <= k <= HOLD_CYCLES, restarts the interval. The low pulse then lasts k + HOLD_CYCLES cycles in one piece. This includes the case k = HOLD_CYCLES, where the request falls on the release edge.
- R5: `busy_o` is 1 exactly while the interval is being counted. That is HOLD_CYCLES cycles for a request pulse and also HOLD_CYCLES cycles after power-up. During the synchroniser delay `busy_o` is 0.
- R6: A loss of `pwr_good_i` during a running pulse aborts it. When power returns, the full R2 sequence follows.
- R7: Requests sampled before the synchronised power-good is high do not change the release timing of R2.
- R8: Once released, `bus_rst_n_o` stays 1 until a request or a power loss occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running timing clock |
| pwr_good_i | input | 1 | Asynchronous power-good; low holds the block in reset |
| sw_rst_req_i | input | 1 | One-cycle hard-reset request strobe |
| bus_rst_n_o | output | 1 | Active-low bus reset |
| busy_o | output | 1 | High while the hold interval is counting |

## Verification
A restart request and the terminal count of the hold counter can fall on the same edge. The request must win, so the pulse extends to twice the interval rather than releasing for one cycle. The bench provokes this by placing the second request exactly HOLD_CYCLES cycles after the first. It also sweeps random gaps on both sides of that point. Each measured low-run length and busy-run length is compared against a closed-form expectation.

A request can also land on the edge where synchronised power-good first rises. The bench provokes this too and checks that the power-up release time is unchanged.

// File: rtl/bus_rst_pkg.sv
package bus_rst_pkg;

  // True when the hold counter sits on its final count.
  function automatic logic is_last(input int unsigned cnt, input int unsigned hold);
    return cnt == hold - 1;
  endfunction

  // Counter value after one counting edge (wraps to zero at the end).
  function automatic int unsigned next_count(input int unsigned cnt, input int unsigned hold);
    return is_last(cnt, hold) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/bus_rst_pg_sync.sv
module bus_rst_pg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) chain_q <= '0;
        else           chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) chain_q <= '0;
        else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bus_rst_hold_timer.sv
module bus_rst_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 200000,
  parameter int unsigned CNT_W       = 18
) (
  input  logic             clk_i,
  input  logic             arst_n_i,
  input  logic             run_i,
  input  logic             restart_i,
  output logic             active_o,
  output logic             last_o,
  output logic [CNT_W-1:0] count_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  assign last_o = bus_rst_pkg::is_last(32'(cnt_q), HOLD_CYCLES);

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (restart_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && run_i) begin
      cnt_q <= CNT_W'(bus_rst_pkg::next_count(32'(cnt_q), HOLD_CYCLES));
      if (last_o) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/bus_rst_seq.sv
module bus_rst_seq #(
  parameter int unsigned HOLD_CYCLES = 200000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic pwr_good_i,
  input  logic sw_rst_req_i,
  output logic bus_rst_n_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;

  logic             pg_sync_w;
  logic             active_w;
  logic             last_w;
  logic [CNT_W-1:0] count_w;

  bus_rst_pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .arst_n_i (pwr_good_i),
    .sync_o   (pg_sync_w)
  );

  bus_rst_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .arst_n_i  (pwr_good_i),
    .run_i     (pg_sync_w),
    .restart_i (sw_rst_req_i),
    .active_o  (active_w),
    .last_o    (last_w),
    .count_o   (count_w)
  );

  // Flop cleared asynchronously by power loss: reset asserts with no clock.
  assign bus_rst_n_o = ~active_w;
  assign busy_o      = active_w & pg_sync_w;
endmodule

// File: rtl/bus_rst_seq_chk.sv
module bus_rst_seq_chk #(
  parameter int unsigned HOLD_CYCLES = 200000,
  parameter int unsigned CNT_W       = 18
) (
  input logic             clk_i,
  input logic             pwr_good_i,
  input logic             sw_rst_req_i,
  input logic             bus_rst_n_o,
  input logic             busy_o,
  input logic             pg_sync_w,
  input logic             last_w,
  input logic [CNT_W-1:0] count_w
);
  // R1
  pwr_off_low_chk: assert property (@(posedge clk_i)
    !pwr_good_i |-> (!bus_rst_n_o && !busy_o));

  // R7
  unsynced_hold_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    !pg_sync_w |=> !bus_rst_n_o);

  // R3
  req_asserts_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    sw_rst_req_i |=> !bus_rst_n_o);

  // R2
  early_release_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (!bus_rst_n_o && !last_w) |=> !bus_rst_n_o);

  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (busy_o && !sw_rst_req_i && !last_w) |=> (count_w == $past(count_w) + 1'b1));

  // R5
  count_range_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    32'(count_w) < HOLD_CYCLES);

  // R8
  stay_released_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (bus_rst_n_o && !sw_rst_req_i) |=> bus_rst_n_o);
endmodule

bind bus_rst_seq bus_rst_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .pwr_good_i   (pwr_good_i),
  .sw_rst_req_i (sw_rst_req_i),
  .bus_rst_n_o  (bus_rst_n_o),
  .busy_o       (busy_o),
  .pg_sync_w    (pg_sync_w),
  .last_w       (last_w),
  .count_w      (count_w)
);

// File: tb/bus_rst_seq_tb.sv
`timescale 1ns/1ps
module bus_rst_seq_tb;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic pg  = 1'b1;
  logic req = 1'b0;
  logic rst_n, busy;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2.5 clk = ~clk;

  bus_rst_seq #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk_i(clk), .pwr_good_i(pg), .sw_rst_req_i(req),
    .bus_rst_n_o(rst_n), .busy_o(busy)
  );

  function automatic int exp_pwrup_low(int h);  return h + 1; endfunction
  function automatic int exp_busy_len(int h);   return h;     endfunction
  function automatic int exp_req_low(int k, int h);
    return (k >= 1 && k <= h) ? k + h : h;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Start at a negedge with the bus released; k<1 means a single request.
  task automatic req_trial(int k, output int low_len, output int busy_len);
    bit ld = 0, bd = 0;
    low_len = 0; busy_len = 0;
    for (int c = 0; c < 4*HOLD + 8; c++) begin
      req = (c == 0 || c == k);
      @(negedge clk);
      if (!ld) begin if (!rst_n) low_len++; else ld = 1; end
      if (!bd) begin if (busy) busy_len++; else bd = 1; end
    end
    req = 0;
  endtask

  // Start at a negedge with pg low; raise it and measure both runs.
  task automatic pwrup_trial(bit req_at_sync, bit req_early, output int low_len, output int busy_len);
    bit ld = 0, bd = 0, bstart = 0;
    low_len = 0; busy_len = 0;
    #1 pg = 1;
    req = req_early;
    for (int c = 0; c < 3*HOLD + 8; c++) begin
      @(negedge clk);
      req = (req_at_sync && c == 0);
      if (!ld) begin if (!rst_n) low_len++; else ld = 1; end
      if (!bd) begin
        if (busy) begin busy_len++; bstart = 1; end
        else if (bstart) bd = 1;
      end
    end
    req = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lo, bu, k;
    void'($urandom(32'd20417));
    #1 pg = 0;
    repeat (3) @(negedge clk);
    check("R1 reset state rst_n", int'(rst_n), 0);
    check("R1 reset state busy", int'(busy), 0);

    pwrup_trial(0, 0, lo, bu);
    check("R2 power-up low length", lo, exp_pwrup_low(HOLD));
    check("R5 power-up busy length", bu, exp_busy_len(HOLD));

    repeat (6) @(negedge clk);
    check("R8 idle stays released", int'(rst_n), 1);

    req_trial(0, lo, bu);
    check("R3 single request low length", lo, exp_req_low(0, HOLD));
    check("R5 single request busy length", bu, exp_busy_len(HOLD));

    req_trial(HOLD, lo, bu);
    check("R4 request on release edge", lo, exp_req_low(HOLD, HOLD));
    req_trial(1, lo, bu);
    check("R4 back-to-back requests", lo, exp_req_low(1, HOLD));
    req_trial(HOLD + 1, lo, bu);
    check("R4 request after release", lo, exp_req_low(HOLD + 1, HOLD));

    // R6: power loss mid-pulse, then R2 again
    @(negedge clk); req = 1; @(negedge clk); req = 0;
    repeat (4) @(negedge clk);
    #1 pg = 0;
    #1 check("R6 R1 immediate assert on loss", int'(rst_n), 0);
    check("R6 busy cleared on loss", int'(busy), 0);
    @(negedge clk); req = 1; @(negedge clk); req = 0; @(negedge clk);
    check("R1 held during power-off", int'(rst_n), 0);
    pwrup_trial(0, 0, lo, bu);
    check("R6 full sequence after restore", lo, exp_pwrup_low(HOLD));

    // R1 loss while idle
    repeat (3) @(negedge clk);
    #1 pg = 0;
    #1 check("R1 immediate assert from idle", int'(rst_n), 0);
    @(negedge clk);
    pwrup_trial(1, 0, lo, bu);
    check("R7 request at sync edge", lo, exp_pwrup_low(HOLD));
    check("R7 busy at sync edge", bu, exp_busy_len(HOLD));

    @(negedge clk); #1 pg = 0; @(negedge clk);
    pwrup_trial(0, 1, lo, bu);
    check("R7 request before sync", lo, exp_pwrup_low(HOLD));

    for (int t = 0; t < 24; t++) begin
      int gap;
      k = int'($urandom_range(0, HOLD + 3));
      req_trial(k, lo, bu);
      check($sformatf("R4 R3 random gap %0d low", k), lo, exp_req_low(k, HOLD));
      check($sformatf("R5 random gap %0d busy", k), bu, exp_req_low(k, HOLD));
      gap = int'($urandom_range(1, 5));
      repeat (gap) @(negedge clk);
      check("R8 released between trials", int'(rst_n), 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule